// File: doc/BRIEF.md
# Translation Cache with Accessed/Dirty Flag Write-Back

A small fully associative translation cache. Each entry maps a virtual page number to a physical page number and also keeps a local copy of that page's accessed and dirty flags as they were last seen in memory. A lookup reports hit and the physical page in the same cycle.

On a load hit whose copy shows the accessed flag clear, or a store hit whose copy shows either flag clear, the block issues one locked read-modify-write request to a memory port. The request asks for only the missing flags to be set. The block then stalls new lookups until that request is acknowledged. When the copy already shows the needed flags set, no memory traffic is made. This saves the costly atomic write.

The entry is never compared against memory again. If software clears a flag in memory, it must invalidate the page so that the next access reloads the flags. Misses are refilled through a plain fill port. Invalidation works on a single page or on the whole cache.

Top module: `xlat_flag_cache`

## Requirements
- R1: A lookup with `req_valid` high raises `hit` in the same cycle, with that entry's `hit_ppn`, when a valid entry holds `req_vpn`. Otherwise `hit` is low.
- R2: A load hit (`req_write`=0) accepted while `req_ready` is high, on an entry whose cached accessed flag is 0, raises `upd_valid` in the next cycle. The request carries `upd_set_acc`=1, `upd_set_dirty`=0 and `upd_vpn` equal to the looked-up page.
- R3: A store hit (`req_write`=1) on an entry with either cached flag clear issues one request. In it, `upd_set_acc` is 1 exactly when the cached accessed flag was 0, and `upd_set_dirty` is 1 exactly when the cached dirty flag was 0.
- R4: A hit whose cached flags already cover the access issues no request, and `upd_valid` stays low.
- R5: While a request is outstanding, `req_ready` is low and `upd_valid`, `upd_vpn` and the set bits hold steady until the cycle in which `upd_ack` is high. In the cycle after that, `upd_valid` is low and `req_ready` is high.
- R6: The cached flags change only when the acknowledge arrives. After that, repeating the same access issues no request.
- R7: A page invalidation (`inv_page`) clears every valid entry holding `inv_vpn` in one cycle. A later refill brings in fresh flags, and a hit then issues the request again if it is needed.
- R8: `inv_all` clears every entry in one cycle, so that all later lookups miss.
- R9: A fill of a page not present writes the round-robin victim slot and advances the pointer. With 8 entries, the ninth distinct fill evicts the first of the previous eight.
- R10: A fill of a page already present rewrites that entry in place and does not advance the victim pointer.
- R11: After reset no entry is valid, `req_ready` is 1 and `upd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation lookup present |
| req_vpn | input | VPN_W | Virtual page to translate |
| req_write | input | 1 | Lookup is for a store |
| req_ready | output | 1 | Block accepts lookups (no request outstanding) |
| hit | output | 1 | Lookup found a valid entry |
| hit_ppn | output | PPN_W | Physical page of the hitting entry |
| fill_valid | input | 1 | Write a translation |
| fill_vpn | input | VPN_W | Virtual page of the fill |
| fill_ppn | input | PPN_W | Physical page of the fill |
| fill_acc | input | 1 | Accessed flag as read from memory |
| fill_dirty | input | 1 | Dirty flag as read from memory |
| inv_page | input | 1 | Invalidate entries matching inv_vpn |
| inv_vpn | input | VPN_W | Page to invalidate |
| inv_all | input | 1 | Invalidate every entry |
| upd_valid | output | 1 | Locked flag-set request outstanding |
| upd_vpn | output | VPN_W | Page whose table entry is to be updated |
| upd_set_acc | output | 1 | Request sets the accessed flag |
| upd_set_dirty | output | 1 | Request sets the dirty flag |
| upd_ack | input | 1 | Memory finished the locked update |

## Verification
On every cycle, the assertions check three things. No lookup can match two entries. A pending request holds its page and set bits until it is acknowledged, and it always sets at least one flag. An acknowledged request leaves the addressed entry's copy showing the set flags. Only the bench's scenarios can show which accesses must produce a request and which must stay silent. The same holds for the stale-copy behaviour that invalidation repairs, and for the order in which the round-robin pointer picks victims across fills, refills and invalidations.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  typedef enum logic {
    UPD_IDLE = 1'b0,
    UPD_WAIT = 1'b1
  } upd_state_e;
endpackage

// File: rtl/xfc_victim_ptr.sv
module xfc_victim_ptr #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [IDX_W-1:0] victim
);
  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (advance) begin
      if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_d = '0;
      else                              ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (advance) ptr_q <= ptr_d;
  end

  assign victim = ptr_q;
endmodule

// File: rtl/xfc_entry_store.sv
module xfc_entry_store #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  // lookup
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_acc,
  output logic             lk_dty,
  // fill
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_acc,
  input  logic             fill_dty,
  input  logic [IDX_W-1:0] fill_victim,
  output logic             fill_present,
  // invalidation
  input  logic             inv_page,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             inv_all,
  // flag refresh after acknowledge
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [VPN_W-1:0] set_vpn,
  input  logic             set_acc,
  input  logic             set_dty
);
  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [ENTRIES-1:0] acc_q, acc_d, dty_q, dty_d;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [VPN_W-1:0]   vpn_d [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_d [ENTRIES];
  logic [ENTRIES-1:0] lk_match, fill_match;
  logic [IDX_W-1:0]   fill_idx, fill_hit_idx;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lk_match[i]   = vld_q[i] && (vpn_q[i] == lk_vpn);
    assign fill_match[i] = vld_q[i] && (vpn_q[i] == fill_vpn);
  end

  always_comb begin
    lk_idx       = '0;
    fill_hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i])   lk_idx       = IDX_W'(i);
      if (fill_match[i]) fill_hit_idx = IDX_W'(i);
    end
  end

  assign lk_hit       = |lk_match;
  assign lk_ppn       = ppn_q[lk_idx];
  assign lk_acc       = acc_q[lk_idx];
  assign lk_dty       = dty_q[lk_idx];
  assign fill_present = |fill_match;
  assign fill_idx     = fill_present ? fill_hit_idx : fill_victim;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      vld_d[i] = vld_q[i];
      acc_d[i] = acc_q[i];
      dty_d[i] = dty_q[i];
      vpn_d[i] = vpn_q[i];
      ppn_d[i] = ppn_q[i];
      if (set_en && set_idx == IDX_W'(i) && vld_q[i] && vpn_q[i] == set_vpn) begin
        acc_d[i] = acc_q[i] | set_acc;
        dty_d[i] = dty_q[i] | set_dty;
      end
      if (fill_en && fill_idx == IDX_W'(i)) begin
        vld_d[i] = 1'b1;
        vpn_d[i] = fill_vpn;
        ppn_d[i] = fill_ppn;
        acc_d[i] = fill_acc;
        dty_d[i] = fill_dty;
      end
      if (inv_all)                                  vld_d[i] = 1'b0;
      else if (inv_page && vpn_d[i] == inv_vpn)     vld_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    acc_q <= acc_d;
    dty_q <= dty_d;
    for (int i = 0; i < ENTRIES; i++) begin
      vpn_q[i] <= vpn_d[i];
      ppn_q[i] <= ppn_d[i];
    end
  end

  p_single_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  p_flags_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && lk_hit && lk_idx == set_idx && lk_vpn == set_vpn && !fill_en && !inv_all && !inv_page)
    |=> ((!$past(set_acc) || acc_q[$past(set_idx)]) && (!$past(set_dty) || dty_q[$past(set_idx)])));
endmodule

// File: rtl/xfc_update_ctl.sv
module xfc_update_ctl
  import xfc_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int IDX_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VPN_W-1:0] start_vpn,
  input  logic [IDX_W-1:0] start_idx,
  input  logic             start_acc,
  input  logic             start_dty,
  input  logic             upd_ack,
  output logic             busy,
  output logic             upd_valid,
  output logic [VPN_W-1:0] upd_vpn,
  output logic             upd_set_acc,
  output logic             upd_set_dirty,
  output logic [IDX_W-1:0] upd_idx,
  output logic             done
);
  upd_state_e       st_q, st_d;
  logic             load;
  logic [VPN_W-1:0] vpn_q;
  logic [IDX_W-1:0] idx_q;
  logic             sa_q, sd_q;

  always_comb begin
    st_d = st_q;
    load = 1'b0;
    done = 1'b0;
    case (st_q)
      UPD_IDLE: if (start) begin
        st_d = UPD_WAIT;
        load = 1'b1;
      end
      UPD_WAIT: if (upd_ack) begin
        st_d = UPD_IDLE;
        done = 1'b1;
      end
      default: st_d = UPD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= UPD_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q <= '0;
      idx_q <= '0;
      sa_q  <= 1'b0;
      sd_q  <= 1'b0;
    end else if (load) begin
      vpn_q <= start_vpn;
      idx_q <= start_idx;
      sa_q  <= start_acc;
      sd_q  <= start_dty;
    end
  end

  assign busy          = (st_q == UPD_WAIT);
  assign upd_valid     = busy;
  assign upd_vpn       = vpn_q;
  assign upd_idx       = idx_q;
  assign upd_set_acc   = sa_q;
  assign upd_set_dirty = sd_q;

  p_hold_until_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_ack) |=> (upd_valid && $stable(upd_vpn)
                                  && $stable(upd_set_acc) && $stable(upd_set_dirty)));

  p_release_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ack) |=> !upd_valid);

  p_sets_some_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (upd_set_acc || upd_set_dirty));
endmodule

// File: rtl/xlat_flag_cache.sv
module xlat_flag_cache #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic             req_write,
  output logic             req_ready,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_acc,
  input  logic             fill_dirty,
  input  logic             inv_page,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             inv_all,
  output logic             upd_valid,
  output logic [VPN_W-1:0] upd_vpn,
  output logic             upd_set_acc,
  output logic             upd_set_dirty,
  input  logic             upd_ack
);
  logic             lk_hit, lk_acc, lk_dty, fill_present, busy, done;
  logic [IDX_W-1:0] lk_idx, victim, upd_idx;
  logic             need_acc, need_dty, start;

  xfc_entry_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
    .clk, .rst_n,
    .lk_vpn(req_vpn), .lk_hit, .lk_idx, .lk_ppn(hit_ppn), .lk_acc, .lk_dty,
    .fill_en(fill_valid), .fill_vpn, .fill_ppn, .fill_acc, .fill_dty(fill_dirty),
    .fill_victim(victim), .fill_present,
    .inv_page, .inv_vpn, .inv_all,
    .set_en(done), .set_idx(upd_idx), .set_vpn(upd_vpn),
    .set_acc(upd_set_acc), .set_dty(upd_set_dirty)
  );

  xfc_victim_ptr #(.ENTRIES(ENTRIES)) u_victim (
    .clk, .rst_n,
    .advance(fill_valid && !fill_present),
    .victim
  );

  assign need_acc = !lk_acc;
  assign need_dty = req_write && !lk_dty;
  assign start    = req_valid && req_ready && lk_hit && (need_acc || need_dty);

  xfc_update_ctl #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_upd (
    .clk, .rst_n,
    .start, .start_vpn(req_vpn), .start_idx(lk_idx),
    .start_acc(need_acc), .start_dty(need_dty),
    .upd_ack, .busy, .upd_valid, .upd_vpn, .upd_set_acc, .upd_set_dirty,
    .upd_idx, .done
  );

  assign req_ready = !busy;
  assign hit       = req_valid && lk_hit;

  p_no_accept_while_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> !req_ready);
endmodule

// File: tb/xlat_flag_cache_tb.sv
module xlat_flag_cache_tb;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, fill_valid = 0, fill_acc = 0, fill_dirty = 0;
  logic inv_page = 0, inv_all = 0, upd_ack = 0;
  logic [VPN_W-1:0] req_vpn = '0, fill_vpn = '0, inv_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic req_ready, hit, upd_valid, upd_set_acc, upd_set_dirty;
  logic [PPN_W-1:0] hit_ppn;
  logic [VPN_W-1:0] upd_vpn;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  xlat_flag_cache #(.ENTRIES(8), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_dut (.*);

  // vector: [12] write, [11:4] vpn, [3] hit, [2] update, [1] set_acc, [0] set_dirty
  localparam logic [12:0] VEC [10] = '{
    {1'b0, 8'h10, 4'b1110},  // R2 load, acc clear
    {1'b0, 8'h10, 4'b1000},  // R6 repeat, no request
    {1'b1, 8'h10, 4'b1101},  // R3 store, dirty only
    {1'b1, 8'h10, 4'b1000},  // R6
    {1'b0, 8'h11, 4'b1000},  // R4
    {1'b1, 8'h11, 4'b1101},  // R3
    {1'b1, 8'h12, 4'b1000},  // R4
    {1'b1, 8'h13, 4'b1111},  // R3 both
    {1'b0, 8'h20, 4'b0000},  // R1 miss
    {1'b0, 8'h13, 4'b1000}   // R6
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [7:0] vpn, input logic [7:0] ppn, input logic a, input logic d);
    @(negedge clk);
    fill_valid = 1; fill_vpn = VPN_W'(vpn); fill_ppn = PPN_W'(ppn); fill_acc = a; fill_dirty = d;
    @(negedge clk);
    fill_valid = 0;
  endtask

  // lookup; checks hit and whether a request follows; acks it
  task automatic access(input logic wr, input logic [7:0] vpn, input logic exp_hit,
                        input logic exp_upd, input logic sa, input logic sd, input string req);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_vpn = VPN_W'(vpn);
    #1;
    chk(hit == exp_hit, req, 32'(hit), 32'(exp_hit));
    if (exp_hit) chk(hit_ppn == PPN_W'(vpn) + PPN_W'(16'h100), req, hit_ppn, PPN_W'(vpn) + 32'h100);
    @(posedge clk); #1;
    req_valid = 0;
    chk(upd_valid == exp_upd, req, 32'(upd_valid), 32'(exp_upd));
    if (exp_upd) begin
      chk({upd_set_acc, upd_set_dirty} == {sa, sd}, req, {upd_set_acc, upd_set_dirty}, {sa, sd});
      chk(upd_vpn == VPN_W'(vpn), req, upd_vpn, vpn);
      chk(req_ready == 0, "R5 ready low", 32'(req_ready), 0);
      @(posedge clk); #1;
      chk(upd_valid == 1 && upd_set_acc == sa, "R5 held", 32'(upd_valid), 1);
      upd_ack = 1;
      @(posedge clk); #1;
      upd_ack = 0;
      chk(upd_valid == 0 && req_ready == 1, "R5 released", {upd_valid, req_ready}, 2'b01);
    end
  endtask

  task automatic probe(input logic [7:0] vpn, input logic [PPN_W-1:0] ppn, input logic exp_hit, input string req);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_vpn = VPN_W'(vpn);
    #1;
    chk(hit == exp_hit, req, 32'(hit), 32'(exp_hit));
    if (exp_hit) chk(hit_ppn == ppn, req, hit_ppn, ppn);
    req_valid = 0;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(req_ready == 1 && upd_valid == 0, "R11 reset", {req_ready, upd_valid}, 2'b10);
    @(negedge clk); rst_n = 1;
    @(negedge clk); req_valid = 1; req_vpn = 'h10; #1;
    chk(hit == 0, "R11 empty", 32'(hit), 0);
    req_valid = 0;

    fill(8'h10, 8'h10 + 8'h00, 0, 0);
    fill_ppn = '0;
    // rewrite ppns as vpn+0x100 via in-place refill (also R10 in-place path)
    fill(8'h10, 8'h00, 0, 0);
    @(negedge clk); fill_valid = 1; fill_vpn = 'h10; fill_ppn = 'h110; fill_acc = 0; fill_dirty = 0;
    @(negedge clk); fill_vpn = 'h11; fill_ppn = 'h111; fill_acc = 1;
    @(negedge clk); fill_vpn = 'h12; fill_ppn = 'h112; fill_dirty = 1;
    @(negedge clk); fill_vpn = 'h13; fill_ppn = 'h113; fill_acc = 0; fill_dirty = 0;
    @(negedge clk); fill_valid = 0;

    for (int i = 0; i < 10; i++) begin
      logic [12:0] v;
      v = VEC[i];
      access(v[12], v[11:4], v[3], v[2], v[1], v[0], $sformatf("R1-vec%0d", i));
    end

    // R7: page invalidation, refill with clear flags, request again
    @(negedge clk); inv_page = 1; inv_vpn = 'h10;
    @(negedge clk); inv_page = 0;
    probe(8'h10, '0, 0, "R7 inval miss");
    probe(8'h11, 'h111, 1, "R7 others kept");
    @(negedge clk); fill_valid = 1; fill_vpn = 'h10; fill_ppn = 'h110; fill_acc = 0; fill_dirty = 0;
    @(negedge clk); fill_valid = 0;
    access(1'b0, 8'h10, 1, 1, 1, 0, "R7 request again");

    // R8
    @(negedge clk); inv_all = 1;
    @(negedge clk); inv_all = 0;
    probe(8'h11, '0, 0, "R8 all cleared");
    probe(8'h13, '0, 0, "R8 all cleared");

    // R9: eight distinct fills then a ninth
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); fill_valid = 1; fill_vpn = VPN_W'(8'h40 + i); fill_ppn = PPN_W'(16'h140 + i);
      fill_acc = 1; fill_dirty = 1;
    end
    @(negedge clk); fill_valid = 0;
    probe(8'h40, '0, 0, "R9 oldest evicted");
    probe(8'h41, 'h141, 1, "R9 second kept");
    probe(8'h48, 'h148, 1, "R9 new present");

    // R10: refill present page in place, pointer not advanced
    @(negedge clk); fill_valid = 1; fill_vpn = 'h42; fill_ppn = 'h2AA;
    @(negedge clk); fill_vpn = 'h49; fill_ppn = 'h149;
    @(negedge clk); fill_vpn = 'h4A; fill_ppn = 'h14A;
    @(negedge clk); fill_valid = 0;
    probe(8'h43, 'h143, 1, "R10 no extra eviction");
    probe(8'h42, '0, 0, "R10 victim order");
    probe(8'h49, 'h149, 1, "R10 new fill");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule